// File: doc/BRIEF.md
# Interrupt Vector Relocation Controller

This block holds the two control bits that decide where the interrupt vector table sits in program flash. It turns them into the table's base word address. One bit selects the table location: either the bottom of flash or the first word of the boot section. The second bit is an arm bit. It must be written to 1 before the select bit will accept a new value, and the new value must follow within a short window. This protects the table location from a stray write.

While the arm bit is set, and for one cycle after a select update, the block raises a suppress output. The interrupt controller gates its global enable with this output. The global enable flag itself is held elsewhere and this block never writes it. The suppress output also follows two lock inputs. One lock forbids interrupts while the CPU runs application code and the vectors live in the boot section. The other forbids interrupts while the CPU runs boot code and the vectors live in the application section.

The boot section size comes from a 2-bit configuration input. The vector fetch logic, flash programming and the CPU core are outside this block.

Top module: `ivr_ctrl`

## Requirements
- R1: After reset, `reg_rdata` is 00, `vec_base` is 0, and `irq_suppress` is 0 when both lock inputs are 0.
- R2: While the select bit (`reg_rdata[1]`) is 0, `vec_base` is 0 whatever the value of `boot_size`.
- R3: While the select bit is 1, `vec_base` is 0xF80, 0xF00, 0xE00 or 0xC00 for `boot_size` 0, 1, 2 or 3 respectively.
- R4: A write with `reg_wdata[0]`=1 sets the arm bit (`reg_rdata[0]`) from the next cycle and leaves the select bit unchanged. `irq_suppress` is 1 while the arm bit is 1.
- R5: A write with `reg_wdata[0]`=0 while the arm bit is 1 loads `reg_wdata[1]` into the select bit and clears the arm bit, both from the next cycle.
- R6: After the select update of R5, `irq_suppress` stays 1 for exactly one more cycle, then falls to 0 if no lock condition applies.
- R7: If no select write follows, the arm bit and `irq_suppress` stay 1 for exactly four cycles after the arming write. The arm bit then clears by itself.
- R8: A write with `reg_wdata[0]`=0 while the arm bit is 0 is ignored: the select bit, `reg_rdata` and `vec_base` keep their values.
- R9: An arming write while the arm bit is already 1 restarts the four-cycle window.
- R10: With the select bit 1, `lock_app_irq`=1 and `in_boot_sec`=0, `irq_suppress` is 1. With `in_boot_sec`=1 this lock has no effect.
- R11: With the select bit 0, `lock_boot_irq`=1 and `in_boot_sec`=1, `irq_suppress` is 1. With `in_boot_sec`=0 this lock has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 2 | Write data: bit 1 is the select value, bit 0 is the arm bit |
| reg_rdata | output | 2 | Read data: {select, arm} |
| boot_size | input | 2 | Boot section size code, 0 is the smallest section |
| lock_app_irq | input | 1 | Forbid interrupts in application code when vectors are in the boot section |
| lock_boot_irq | input | 1 | Forbid interrupts in boot code when vectors are in the application section |
| in_boot_sec | input | 1 | 1 while the CPU is executing from the boot section |
| vec_base | output | 12 | Word address of the vector table base |
| irq_suppress | output | 1 | 1 when the interrupt controller must hold off interrupts |

## Verification
The assertions check four things on every cycle:
- the select bit moves only on an accepted write;
- an arming write always leaves the arm bit set;
- an accepted write always clears the arm bit and keeps suppression for the following cycle;
- a zero select always gives a zero base.

Some behaviour only the bench's scenarios can show:
- the exact four-cycle length of the window;
- the window restarting on a second arming write;
- ignored writes just after the window expires;
- the four base addresses;
- both lock cases, including their inactive halves.

// File: rtl/ivr_pkg.sv
// Package: shared constants and the boot-start address computation.
// Assumes the boot section doubles in size with each step of the size code.
package ivr_pkg;
    localparam int FLASH_WORDS = 4096;
    localparam int MIN_BOOT_WORDS = 128;
    localparam int ADDR_W = $clog2(FLASH_WORDS);

    // Word address where a boot section of the given size code begins.
    function automatic int boot_start(input int flash_words, input int min_boot,
                                      input logic [1:0] size_code);
        return flash_words - (min_boot << size_code);
    endfunction
endpackage

// File: rtl/ivr_unlock.sv
// Module: the select/arm register with its timed unlock window.
// Assumes one write strobe per cycle. An arming write (data bit 0 = 1) opens a
// window of WIN cycles. A disarming write inside the window updates the select bit.
module ivr_unlock #(
    parameter int WIN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_wdata,
    output logic       sel_q,
    output logic       arm_q,
    output logic       post_q
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] cnt_q;
    logic          accept;

    // A select update is accepted only while armed and with the arm bit written 0.
    assign accept = arm_q && reg_wr && !reg_wdata[0];

    // Register state, window counter and the one-cycle trailing mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            arm_q  <= 1'b0;
            post_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            post_q <= accept;
            if (reg_wr && reg_wdata[0]) begin
                arm_q <= 1'b1;
                cnt_q <= CW'(WIN);
            end else if (accept) begin
                sel_q <= reg_wdata[1];
                arm_q <= 1'b0;
                cnt_q <= '0;
            end else if (arm_q) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) arm_q <= 1'b0;
            end
        end
    end

    assert_sel_only_on_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(sel_q));
    assert_arm_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[0]) |=> arm_q);
    assert_accept_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!arm_q && sel_q == $past(reg_wdata[1])));
    assert_arm_has_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q |-> (cnt_q != '0 && cnt_q <= CW'(WIN)));
endmodule

// File: rtl/ivr_base.sv
// Module: maps the select bit and boot size code to the vector table base.
// Assumes the flash size is a power of two, so the base fits in AW bits.
module ivr_base #(
    parameter int FLASH_WORDS = ivr_pkg::FLASH_WORDS,
    parameter int MIN_BOOT    = ivr_pkg::MIN_BOOT_WORDS,
    parameter int AW          = $clog2(FLASH_WORDS)
) (
    input  logic          sel,
    input  logic [1:0]    boot_size,
    output logic [AW-1:0] vec_base
);
    // Choose address zero or the start of the boot section.
    always_comb begin
        if (sel) vec_base = AW'(ivr_pkg::boot_start(FLASH_WORDS, MIN_BOOT, boot_size));
        else     vec_base = '0;
    end
endmodule

// File: rtl/ivr_suppress.sv
// Module: combines the unlock-window mask and the two lock conditions.
// Assumes the interrupt controller ANDs the inverse of this output with its global enable.
module ivr_suppress (
    input  logic sel,
    input  logic arm,
    input  logic post,
    input  logic lock_app_irq,
    input  logic lock_boot_irq,
    input  logic in_boot_sec,
    output logic irq_suppress
);
    logic lock_hit;

    // A lock applies only when the code runs in the section that does not hold the vectors.
    always_comb begin
        lock_hit = (sel && lock_app_irq && !in_boot_sec) ||
                   (!sel && lock_boot_irq && in_boot_sec);
        irq_suppress = arm || post || lock_hit;
    end
endmodule

// File: rtl/ivr_ctrl.sv
// Module: top of the vector relocation controller.
// Assumes the CPU writes the register through a single-cycle strobe and reads it combinationally.
module ivr_ctrl #(
    parameter int WIN         = 4,
    parameter int FLASH_WORDS = ivr_pkg::FLASH_WORDS,
    parameter int MIN_BOOT    = ivr_pkg::MIN_BOOT_WORDS,
    parameter int AW          = $clog2(FLASH_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_wdata,
    output logic [1:0]    reg_rdata,
    input  logic [1:0]    boot_size,
    input  logic          lock_app_irq,
    input  logic          lock_boot_irq,
    input  logic          in_boot_sec,
    output logic [AW-1:0] vec_base,
    output logic          irq_suppress
);
    logic sel, arm, post;

    ivr_unlock #(.WIN(WIN)) u_unlock (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .sel_q(sel), .arm_q(arm), .post_q(post)
    );

    ivr_base #(.FLASH_WORDS(FLASH_WORDS), .MIN_BOOT(MIN_BOOT), .AW(AW)) u_base (
        .sel(sel), .boot_size(boot_size), .vec_base(vec_base)
    );

    ivr_suppress u_supp (
        .sel(sel), .arm(arm), .post(post), .lock_app_irq(lock_app_irq),
        .lock_boot_irq(lock_boot_irq), .in_boot_sec(in_boot_sec),
        .irq_suppress(irq_suppress)
    );

    // Read port returns the two register bits.
    assign reg_rdata = {sel, arm};

    assert_base_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[1] |-> vec_base == '0);
    assert_mask_after_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[0] && reg_wr && !reg_wdata[0]) |=> irq_suppress);
    assert_mask_while_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[0] |-> irq_suppress);
endmodule

// File: tb/sim_ivr_ctrl.sv
// Scoreboard bench: the driver queues expected outputs, the monitor compares after each edge.
module sim_ivr_ctrl;
    localparam int PERIOD = 10;

    typedef struct {
        logic [1:0]  rd;
        logic [11:0] base;
        logic        sup;
        string       tag;
    } exp_t;

    logic        clk = 0, rst_n = 0, reg_wr = 0;
    logic [1:0]  reg_wdata = 0, boot_size = 2'd3, reg_rdata;
    logic        lock_app_irq = 0, lock_boot_irq = 0, in_boot_sec = 0;
    logic [11:0] vec_base;
    logic        irq_suppress;
    exp_t        q[$];
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    ivr_ctrl u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .boot_size(boot_size), .lock_app_irq(lock_app_irq),
        .lock_boot_irq(lock_boot_irq), .in_boot_sec(in_boot_sec),
        .vec_base(vec_base), .irq_suppress(irq_suppress));

    always #(PERIOD/2) clk = ~clk;

    // Drive one cycle of inputs and queue the outputs expected after the next edge.
    task automatic step(input logic wr, input logic [1:0] wd, input logic [1:0] bs,
                        input logic la, input logic lb, input logic ib,
                        input logic [1:0] erd, input logic [11:0] ebase,
                        input logic esup, input string tag);
        exp_t e;
        @(negedge clk);
        reg_wr = wr; reg_wdata = wd; boot_size = bs;
        lock_app_irq = la; lock_boot_irq = lb; in_boot_sec = ib;
        e.rd = erd; e.base = ebase; e.sup = esup; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare the queue head shortly after each rising edge.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (reg_rdata !== e.rd || vec_base !== e.base || irq_suppress !== e.sup) begin
                n_fail++;
                $display("FAIL %s: rdata=%b base=%h sup=%b expected rdata=%b base=%h sup=%b",
                         e.tag, reg_rdata, vec_base, irq_suppress, e.rd, e.base, e.sup);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step(0, 2'b00, 3, 0, 0, 0, 2'b00, 12'h000, 0, "R1 reset state");
        step(1, 2'b10, 3, 0, 0, 0, 2'b00, 12'h000, 0, "R8 select write while disarmed");
        step(1, 2'b01, 3, 0, 0, 0, 2'b01, 12'h000, 1, "R4 arm write");
        step(0, 2'b00, 3, 0, 0, 0, 2'b01, 12'h000, 1, "R4 still armed");
        step(1, 2'b10, 3, 0, 0, 0, 2'b10, 12'hC00, 1, "R5 select update in window");
        step(0, 2'b00, 3, 0, 0, 0, 2'b10, 12'hC00, 0, "R6 mask released");
        step(0, 2'b00, 0, 0, 0, 0, 2'b10, 12'hF80, 0, "R3 size 0");
        step(0, 2'b00, 1, 0, 0, 0, 2'b10, 12'hF00, 0, "R3 size 1");
        step(0, 2'b00, 2, 0, 0, 0, 2'b10, 12'hE00, 0, "R3 size 2");
        step(1, 2'b01, 3, 0, 0, 0, 2'b11, 12'hC00, 1, "R4 arm keeps select");
        for (int i = 0; i < 3; i++)
            step(0, 2'b00, 3, 0, 0, 0, 2'b11, 12'hC00, 1, "R7 window open");
        step(0, 2'b00, 3, 0, 0, 0, 2'b10, 12'hC00, 0, "R7 window expired");
        step(1, 2'b00, 3, 0, 0, 0, 2'b10, 12'hC00, 0, "R8 write after window");
        step(1, 2'b01, 3, 0, 0, 0, 2'b11, 12'hC00, 1, "R9 first arm");
        step(0, 2'b00, 3, 0, 0, 0, 2'b11, 12'hC00, 1, "R9 armed");
        step(0, 2'b00, 3, 0, 0, 0, 2'b11, 12'hC00, 1, "R9 armed");
        step(1, 2'b11, 3, 0, 0, 0, 2'b11, 12'hC00, 1, "R9 rearm");
        for (int i = 0; i < 3; i++)
            step(0, 2'b00, 3, 0, 0, 0, 2'b11, 12'hC00, 1, "R9 window restarted");
        step(0, 2'b00, 3, 0, 0, 0, 2'b10, 12'hC00, 0, "R9 restarted window expired");
        step(1, 2'b01, 3, 0, 0, 0, 2'b11, 12'hC00, 1, "R4 arm");
        step(1, 2'b00, 3, 0, 0, 0, 2'b00, 12'h000, 1, "R5 clear select");
        step(0, 2'b00, 2, 0, 0, 0, 2'b00, 12'h000, 0, "R2 base zero, R6 release");
        step(0, 2'b00, 2, 0, 1, 1, 2'b00, 12'h000, 1, "R11 boot lock in boot");
        step(0, 2'b00, 2, 0, 1, 0, 2'b00, 12'h000, 0, "R11 boot lock in app");
        step(0, 2'b00, 2, 1, 0, 0, 2'b00, 12'h000, 0, "R10 app lock with select 0");
        step(1, 2'b01, 2, 0, 0, 0, 2'b01, 12'h000, 1, "R4 arm");
        step(1, 2'b10, 2, 0, 0, 0, 2'b10, 12'hE00, 1, "R5 set select");
        step(0, 2'b00, 2, 0, 0, 0, 2'b10, 12'hE00, 0, "R6 release");
        step(0, 2'b00, 2, 1, 0, 0, 2'b10, 12'hE00, 1, "R10 app lock in app");
        step(0, 2'b00, 2, 1, 0, 1, 2'b10, 12'hE00, 0, "R10 app lock in boot");
        step(0, 2'b00, 2, 0, 1, 1, 2'b10, 12'hE00, 0, "R11 boot lock with select 1");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(PERIOD * 5000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule